// File: doc/BRIEF.md
# Non-Volatile Memory Program/Erase Controller

This block sits between a register bus and an on-chip non-volatile memory array. Software loads a target address, a data word and an operation code into registers, then sets a start bit to run a single-word program or a page erase. The start bit is protected. It only takes effect when the write-enable bit is already set and three key words have just been written, in a fixed order, to a key register. Every register accepts three write flavours: a plain write that replaces the value, a set flavour that ORs in the written ones, and a clear flavour that removes the written ones.

An accepted program or erase raises the busy flag and presents one command on a valid/ready port toward the array. The command fields stay frozen while `cmd_valid` is high and `cmd_ready` is low. The transfer happens on the first clock edge where both are high. After the handshake, a behavioural completion counter stands in for the cell timing and drops busy after a fixed number of cycles per operation. A rejected start sets a write-error flag. A start taken while the `lv_low` pin is high is aborted and sets a low-voltage flag. A no-operation run through the same unlock-and-start path clears both flags.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, control, address and data registers read zero, the key tracker is locked, `busy` and `cmd_valid` are low.
- R2: Register select `wr_reg` is 0 control, 1 key, 2 address, 3 data. Flavour `wr_alias` is 0 plain (replace), 1 set (OR), 2 clear (AND with inverted data) and 3 (write dropped). The address register keeps its low FADDR_W bits and reads zero above them. The key register reads zero.
- R3: Control register layout: op in bits 3:0, low-voltage error bit 12, write error bit 13, write-enable bit 14, start/busy bit 15. The tracker unlocks only after the key words 0x00000000, 0xAA996655, 0x556699AA are written in that order while write-enable is set. A wrong word, or a key write with write-enable clear, returns it to locked.
- R4: A control write whose resulting bit 15 is 1 is a start attempt. It uses the newly written op code 0 (no-op), 1 (word program) or 4 (page erase). It is accepted only when the tracker is unlocked, the stored write-enable was already 1 and the op code is legal. Otherwise busy stays low and the write-error bit is set.
- R5: Any start attempt locks the tracker again, and so does any write to the control, address or data register.
- R6: An accepted program or erase drives `cmd_valid` with `cmd_op`, `cmd_addr` and `cmd_data`. `cmd_data` is the data register for program and zero for erase. The fields hold stable until `cmd_ready` is seen high.
- R7: Busy falls exactly PROG_LAT (program) or ERASE_LAT (erase) clock edges after the handshake edge.
- R8: While busy is high, every register write, including key writes, is ignored.
- R9: If `lv_low` is high at an accepted start, no command is issued, busy stays low and the low-voltage error bit is set.
- R10: An accepted no-op raises busy for one cycle, issues no command and then clears both error bits.
- R11: Software writes never change the two error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 2 | Register select for the write |
| wr_alias | input | 2 | Write flavour: plain, set, clear |
| wr_data | input | 32 | Write data |
| rd_reg | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| lv_low | input | 1 | Supply-low indication |
| busy | output | 1 | Operation in progress |
| cmd_valid | output | 1 | Array command valid |
| cmd_ready | input | 1 | Array accepts command |
| cmd_op | output | 4 | Array command op code |
| cmd_addr | output | FADDR_W | Array command address |
| cmd_data | output | 32 | Array command data |

## Verification
Random plain, set, clear and reserved writes to the address, data and control registers tell apart the three write flavours. They also show that the error bits cannot be touched by software. Directed key sequences cover several cases: the correct order, a swapped order, a missing write-enable, an intervening address write and a reused unlock. Together these separate a tracker that checks order and consumption from one that only counts key writes. Program and erase runs use random addresses, data and ready delays. They show that the command fields hold under back-pressure, that erase zeroes the data, and that busy falls on the exact edge set by each latency. Supply-low, illegal-op and no-op recovery runs separate the abort path, the reject path and the flag-clearing path.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_KEY  = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam logic [1:0] WA_PLAIN = 2'd0;
  localparam logic [1:0] WA_SET   = 2'd1;
  localparam logic [1:0] WA_CLR   = 2'd2;
  localparam logic [1:0] WA_NONE  = 2'd3;

  localparam logic [3:0] OPC_NOP   = 4'd0;
  localparam logic [3:0] OPC_PROG  = 4'd1;
  localparam logic [3:0] OPC_ERASE = 4'd4;

  localparam int B_START = 15;
  localparam int B_WREN  = 14;
  localparam int B_WERR  = 13;
  localparam int B_LVERR = 12;

  localparam logic [31:0] KEY_A = 32'h0000_0000;
  localparam logic [31:0] KEY_B = 32'hAA99_6655;
  localparam logic [31:0] KEY_C = 32'h5566_99AA;

  typedef enum logic [1:0] {LK_WANT_A, LK_WANT_B, LK_WANT_C, LK_OPEN} lock_st_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_RUN, SQ_NOP} seq_st_e;

  function automatic logic [31:0] merge_write(input logic [1:0] fl,
                                              input logic [31:0] cur,
                                              input logic [31:0] wd);
    case (fl)
      WA_PLAIN: merge_write = wd;
      WA_SET:   merge_write = cur | wd;
      WA_CLR:   merge_write = cur & ~wd;
      default:  merge_write = cur;
    endcase
  endfunction

  function automatic logic op_legal(input logic [3:0] op);
    op_legal = (op == OPC_NOP) || (op == OPC_PROG) || (op == OPC_ERASE);
  endfunction
endpackage

// File: rtl/nvm_key_lock.sv
module nvm_key_lock
  import nvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        other_wr,
  input  logic        wren,
  output logic        unlocked
);
  lock_st_e st_q;
  lock_st_e st_adv;
  logic [31:0] want;

  always_comb begin
    case (st_q)
      LK_WANT_A: begin want = KEY_A; st_adv = LK_WANT_B; end
      LK_WANT_B: begin want = KEY_B; st_adv = LK_WANT_C; end
      LK_WANT_C: begin want = KEY_C; st_adv = LK_OPEN;   end
      default:   begin want = KEY_A; st_adv = LK_WANT_A; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= LK_WANT_A;
    end else if (other_wr) begin
      st_q <= LK_WANT_A;
    end else if (key_wr) begin
      if (wren && (st_q != LK_OPEN) && (key_data == want)) st_q <= st_adv;
      else st_q <= LK_WANT_A;
    end
  end

  assign unlocked = (st_q == LK_OPEN);

  // R5: a non-key write always locks
  p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> !unlocked);
  // R3: opening only follows a key write with write-enable set
  p_open_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && wren && key_data == KEY_C));
endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
  import nvm_pkg::*;
#(
  parameter int FADDR_W   = 24,
  parameter int PROG_LAT  = 8,
  parameter int ERASE_LAT = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               reject,
  input  logic [3:0]         op,
  input  logic [FADDR_W-1:0] addr,
  input  logic [31:0]        data,
  input  logic               lv_low,
  input  logic               cmd_ready,
  output logic               busy,
  output logic               werr,
  output logic               lverr,
  output logic               cmd_valid,
  output logic [3:0]         cmd_op,
  output logic [FADDR_W-1:0] cmd_addr,
  output logic [31:0]        cmd_data
);
  localparam int MAX_LAT = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] PL = CNT_W'(PROG_LAT);
  localparam logic [CNT_W-1:0] EL = CNT_W'(ERASE_LAT);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      cnt_q    <= '0;
      werr     <= 1'b0;
      lverr    <= 1'b0;
      cmd_op   <= '0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (reject) begin
            werr <= 1'b1;
          end else if (go) begin
            if (!op_legal(op)) begin
              werr <= 1'b1;
            end else if (lv_low) begin
              lverr <= 1'b1;
            end else if (op == OPC_NOP) begin
              st_q <= SQ_NOP;
            end else begin
              cmd_op   <= op;
              cmd_addr <= addr;
              cmd_data <= (op == OPC_PROG) ? data : 32'd0;
              st_q     <= SQ_ISSUE;
            end
          end
        end
        SQ_ISSUE: begin
          if (cmd_ready) begin
            cnt_q <= (cmd_op == OPC_PROG) ? PL : EL;
            st_q  <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (cnt_q <= 1) st_q <= SQ_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          werr  <= 1'b0;
          lverr <= 1'b0;
          st_q  <= SQ_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign cmd_valid = (st_q == SQ_ISSUE);

  // R6: command fields frozen under back-pressure
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                   $stable(cmd_addr) && $stable(cmd_data)));
  // R9: supply-low abort
  p_lv_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !reject && !busy && lv_low && op_legal(op)) |=> (!busy && lverr));
  // R4: rejected start keeps busy low and flags the error
  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !busy) |=> (!busy && werr));
  // R10: no-op ends cleanly next cycle
  p_nop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_valid && $past(!busy)) |=> (!busy && !werr && !lverr));
  // R7: completion counter never underflows
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN) |-> (cnt_q != 0 && cnt_q <= CNT_W'(MAX_LAT)));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int FADDR_W   = 24,
  parameter int PROG_LAT  = 8,
  parameter int ERASE_LAT = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_reg,
  input  logic [1:0]         wr_alias,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         rd_reg,
  output logic [31:0]        rd_data,
  input  logic               lv_low,
  output logic               busy,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [3:0]         cmd_op,
  output logic [FADDR_W-1:0] cmd_addr,
  output logic [31:0]        cmd_data
);
  localparam int PAD_W = 32 - FADDR_W;

  logic [3:0]         op_q;
  logic               wren_q;
  logic [FADDR_W-1:0] addr_q;
  logic [31:0]        data_q;
  logic               werr, lverr, unlocked;
  logic [31:0]        ctrl_view, ctrl_new, addr_new, data_new;
  logic               live, start_try, start_ok, start_bad;

  assign ctrl_view = {16'd0, busy, wren_q, werr, lverr, 8'd0, op_q};
  assign live      = wr_en && !busy && (wr_alias != WA_NONE);
  assign ctrl_new  = merge_write(wr_alias, ctrl_view, wr_data);
  assign addr_new  = merge_write(wr_alias, {{PAD_W{1'b0}}, addr_q}, wr_data);
  assign data_new  = merge_write(wr_alias, data_q, wr_data);
  assign start_try = live && (wr_reg == REG_CTRL) && ctrl_new[B_START];
  assign start_ok  = start_try && unlocked && wren_q;
  assign start_bad = start_try && !start_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      wren_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (live) begin
      case (wr_reg)
        REG_CTRL: begin
          op_q   <= ctrl_new[3:0];
          wren_q <= ctrl_new[B_WREN];
        end
        REG_ADDR: addr_q <= addr_new[FADDR_W-1:0];
        REG_DATA: data_q <= data_new;
        default: ;
      endcase
    end
  end

  nvm_key_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (live && (wr_reg == REG_KEY)),
    .key_data (wr_data),
    .other_wr (live && (wr_reg != REG_KEY)),
    .wren     (wren_q),
    .unlocked (unlocked)
  );

  nvm_op_seq #(
    .FADDR_W   (FADDR_W),
    .PROG_LAT  (PROG_LAT),
    .ERASE_LAT (ERASE_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (start_ok),
    .reject    (start_bad),
    .op        (ctrl_new[3:0]),
    .addr      (addr_q),
    .data      (data_q),
    .lv_low    (lv_low),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .werr      (werr),
    .lverr     (lverr),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  always_comb begin
    case (rd_reg)
      REG_CTRL: rd_data = ctrl_view;
      REG_ADDR: rd_data = {{PAD_W{1'b0}}, addr_q};
      REG_DATA: rd_data = data_q;
      default:  rd_data = 32'd0;
    endcase
  end

  // R8: writes during an operation leave registers untouched
  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));
  // R4: a locked start never raises busy
  p_locked_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_try && !unlocked) |=> !busy);
  // R6: a command is only offered while busy
  p_cmd_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
  localparam int FW = 24;
  localparam int PL = 8;
  localparam int EL = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_reg = '0, wr_alias = '0, rd_reg = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic lv_low = 1'b0, cmd_ready = 1'b0;
  logic busy, cmd_valid;
  logic [3:0] cmd_op;
  logic [FW-1:0] cmd_addr;
  logic [31:0] cmd_data;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_addr = '0, m_data = '0;
  logic [3:0] m_op = '0;
  logic m_wren = 1'b0;
  logic [31:0] u;

  nvm_ctrl #(.FADDR_W(FW), .PROG_LAT(PL), .ERASE_LAT(EL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_alias(wr_alias), .wr_data(wr_data), .rd_reg(rd_reg),
    .rd_data(rd_data), .lv_low(lv_low), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  always #2 clk = ~clk;

  function automatic logic [31:0] fmerge(logic [1:0] fl, logic [31:0] c, logic [31:0] d);
    if (fl == 2'd0) return d;
    if (fl == 2'd1) return c | d;
    if (fl == 2'd2) return c & ~d;
    return c;
  endfunction

  function automatic logic [31:0] fctrl(logic b, logic we, logic e1, logic e0, logic [3:0] op);
    return {16'd0, b, we, e1, e0, 8'd0, op};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] r, logic [1:0] fl, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = r; wr_alias = fl; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] r, output logic [31:0] v);
    rd_reg = r; #0.1; v = rd_data;
  endtask

  task automatic unlock();
    wr(2'd1, 2'd0, 32'h0000_0000);
    wr(2'd1, 2'd0, 32'hAA99_6655);
    wr(2'd1, 2'd0, 32'h5566_99AA);
  endtask

  task automatic serve(string tag, int lat, logic [3:0] eop, logic [31:0] ea,
                       logic [31:0] ed, int dly);
    chk({tag, " R6 valid"}, {31'd0, cmd_valid}, 32'd1);
    chk({tag, " R6 op"}, {28'd0, cmd_op}, {28'd0, eop});
    chk({tag, " R6 addr"}, {8'd0, cmd_addr}, ea & 32'h00FF_FFFF);
    chk({tag, " R6 data"}, cmd_data, ed);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk({tag, " R6 hold"}, {cmd_valid, cmd_op, cmd_addr[19:0], busy},
          {1'b1, eop, ea[19:0], 1'b1});
    end
    cmd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_ready = 1'b0;
    chk({tag, " R6 drop"}, {31'd0, cmd_valid}, 32'd0);
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      if (busy !== 1'b1) chk({tag, " R7 early"}, {31'd0, busy}, 32'd1);
    end
    @(negedge clk);
    chk({tag, " R7 done"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic run_nop();
    wr(2'd0, 2'd0, 32'h0000_4000);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk("R10 nop busy", {30'd0, busy, cmd_valid}, 32'd2);
    @(negedge clk);
    rd(2'd0, u);
    chk("R10 nop clear", u, fctrl(1'b0, 1'b1, 1'b0, 1'b0, 4'd0));
    wr(2'd0, 2'd2, 32'h0000_4000);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, u); chk("R1 ctrl", u, 32'd0);
    rd(2'd2, u); chk("R1 addr", u, 32'd0);
    rd(2'd3, u); chk("R1 data", u, 32'd0);
    chk("R1 outs", {30'd0, busy, cmd_valid}, 32'd0);

    // R2 / R11 random aliased writes
    for (int i = 0; i < 200; i++) begin
      logic [1:0] r, fl;
      logic [31:0] d, nc;
      r  = 2'($urandom_range(0, 3));
      fl = 2'($urandom_range(0, 3));
      d  = $urandom;
      if (r == 2'd0 && fl != 2'd2) d[15] = 1'b0;
      wr(r, fl, d);
      case (r)
        2'd0: begin
          nc = fmerge(fl, fctrl(1'b0, m_wren, 1'b0, 1'b0, m_op), d);
          m_op = nc[3:0]; m_wren = nc[14];
        end
        2'd2: m_addr = fmerge(fl, m_addr, d) & 32'h00FF_FFFF;
        2'd3: m_data = fmerge(fl, m_data, d);
        default: ;
      endcase
      rd(r, u);
      if (r == 2'd0) chk("R2 R11 ctrl", u, fctrl(1'b0, m_wren, 1'b0, 1'b0, m_op));
      else if (r == 2'd1) chk("R2 key reads zero", u, 32'd0);
      else if (r == 2'd2) chk("R2 addr", u, m_addr);
      else chk("R2 data", u, m_data);
    end
    wr(2'd0, 2'd0, 32'd0);

    // R3 R4 R6 R7 program, then erase
    wr(2'd2, 2'd0, 32'h0012_3454);
    wr(2'd3, 2'd0, 32'hDEAD_BEEF);
    wr(2'd0, 2'd0, 32'h0000_4001);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    serve("prog", PL, 4'd1, 32'h0012_3454, 32'hDEAD_BEEF, 3);
    rd(2'd0, u); chk("R4 prog ok", u, fctrl(1'b0, 1'b1, 1'b0, 1'b0, 4'd1));
    wr(2'd0, 2'd0, 32'h0000_4004);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    serve("erase", EL, 4'd4, 32'h0012_3454, 32'd0, 0);

    // R8 writes while busy ignored
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    wr(2'd2, 2'd0, 32'h00AB_CDEF);
    wr(2'd1, 2'd0, 32'h0);
    serve("busy", EL, 4'd4, 32'h0012_3454, 32'd0, 1);
    rd(2'd2, u); chk("R8 addr kept", u, 32'h0012_3454);

    // R3 wrong order -> reject
    wr(2'd1, 2'd0, 32'h0);
    wr(2'd1, 2'd0, 32'h5566_99AA);
    wr(2'd1, 2'd0, 32'hAA99_6655);
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk("R3 order busy", {31'd0, busy}, 32'd0);
    rd(2'd0, u); chk("R3 R4 order werr", u, fctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd4));
    run_nop();

    // R3 no write-enable
    wr(2'd0, 2'd0, 32'h0000_0001);
    unlock();
    wr(2'd0, 2'd0, 32'h0000_C001);
    rd(2'd0, u); chk("R3 no wren", u, fctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd1));
    run_nop();

    // R5 cancel by address write, then reuse of consumed unlock
    wr(2'd0, 2'd0, 32'h0000_4001);
    unlock();
    wr(2'd2, 2'd1, 32'h0000_0000);
    wr(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, u); chk("R5 cancel", u, fctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd1));
    run_nop();
    wr(2'd0, 2'd0, 32'h0000_4000);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    @(negedge clk);
    wr(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, u); chk("R5 reuse", u, fctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd0));
    run_nop();

    // R4 illegal op code
    wr(2'd0, 2'd0, 32'h0000_4002);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk("R4 illegal busy", {31'd0, busy}, 32'd0);
    rd(2'd0, u); chk("R4 illegal werr", u, fctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd2));
    run_nop();

    // R9 supply low
    lv_low = 1'b1;
    wr(2'd0, 2'd0, 32'h0000_4001);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk("R9 no cmd", {30'd0, busy, cmd_valid}, 32'd0);
    rd(2'd0, u); chk("R9 lverr", u, fctrl(1'b0, 1'b1, 1'b0, 1'b1, 4'd1));
    wr(2'd0, 2'd0, 32'h0000_3000);
    rd(2'd0, u); chk("R11 flags kept", u, fctrl(1'b0, 1'b0, 1'b0, 1'b1, 4'd0));
    lv_low = 1'b0;
    run_nop();

    // R6 R7 random programs with random back-pressure
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, d;
      a = $urandom & 32'h00FF_FFFC;
      d = $urandom;
      wr(2'd2, 2'd0, a);
      wr(2'd3, 2'd0, d);
      wr(2'd0, 2'd0, 32'h0000_4001);
      unlock();
      wr(2'd0, 2'd1, 32'h0000_8000);
      serve("rand prog", PL, 4'd1, a, d, int'($urandom_range(0, 5)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule